// File: doc/BRIEF.md
# Smart-Card Serial Character Receiver

This block takes one asynchronous serial line and recovers character frames of the shape used on smart-card links: a low start bit, eight data bits, one parity bit and one or two high stop bits. The bit period is a run-time count of system clocks. The block oversamples the line on the system clock and takes one sample at the centre of each bit. It delivers the received byte with three sticky flags: byte ready, overrun and frame error. An acknowledge input clears all three flags.

Progress is reported on three outputs. `start_seen` is high while a falling edge is under test. `rx_active` goes high once the middle of the start bit has confirmed that edge. `frame_end` pulses during the last clock of the final stop bit. A short glitch on the line raises `start_seen` but never `rx_active`. Bit order, parity sense and stop-bit count are inputs. They are captured only while the receiver is idle, so a change made during a frame takes effect on the next frame.

Top module: `sc_serial_rx`

## Requirements
- R1: `bit_period` gives the bit length in system clocks at run time. Its width parameter is at least 13 bits, so a period of 372 clocks receives correctly.
- R2: With `msb_first`=0 the first data bit after the start bit is rx_byte[0] and the last is rx_byte[7]. With `msb_first`=1 the first is rx_byte[7] and the last is rx_byte[0].
- R3: With `odd_parity`=1 the eight data bits plus the parity bit must hold an odd number of ones. With 0 they must hold an even number. A frame that meets this rule and has good stop bits sets `byte_ready`.
- R4: With `two_stop`=0 a frame has one stop bit. With 1 it has two, and both are sampled.
- R5: A parity fault, or any stop bit sampled low, sets `frame_err`. It leaves `rx_byte` and `byte_ready` unchanged.
- R6: If a good frame completes while `byte_ready` is still 1 and `ack` is low, `overrun_err` sets and `rx_byte` takes the new byte.
- R7: `frame_end` is high for exactly one clock. With the default of 2 synchroniser stages, that clock is 2 + N×period clocks after the line falls, where N is 11 or 12 bits per frame.
- R8: `start_seen` rises after a falling line edge. `rx_active` rises only when the start bit still reads low at mid-bit. A low pulse shorter than half a bit returns the block to idle with no flag and no `frame_end`.
- R9: Every frame confirmed by `rx_active` ends with `frame_end`, and after it `byte_ready` or `frame_err` is set.
- R10: `ack` clears `byte_ready`, `overrun_err` and `frame_err`. If a frame completes in the same clock, the new result wins.
- R11: Order, parity and stop-count inputs are captured only while idle. Changing them during a frame does not affect that frame.
- R12: Active-low asynchronous `rst_n` clears all flags and progress outputs and returns the receiver to idle, even in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_in | input | 1 | Serial line, idle high |
| bit_period | input | PERIOD_W | Clocks per bit |
| msb_first | input | 1 | 1: most significant bit sent first |
| odd_parity | input | 1 | 1: odd parity, 0: even |
| two_stop | input | 1 | 1: two stop bits |
| ack | input | 1 | Clears the three flags |
| rx_byte | output | DATA_W | Last good byte received |
| byte_ready | output | 1 | A good byte is waiting |
| overrun_err | output | 1 | A byte was replaced before ack |
| frame_err | output | 1 | Parity or stop-bit fault |
| start_seen | output | 1 | Edge under test, start not yet confirmed |
| rx_active | output | 1 | Frame confirmed and in progress |
| frame_end | output | 1 | One-clock pulse in the last stop-bit clock |

## Verification
The bench sends a fault in the second stop bit. A receiver that samples only one stop bit would report that frame as good. It also sends a low glitch shorter than half a bit. A receiver that confirms the start on the edge alone would go on to decode a phantom frame and pulse `frame_end`. Bit order and parity are flipped in the middle of a frame. A design that reads its configuration live would then reverse the byte or report a false parity fault. Other cases cover two unacknowledged frames, which must raise overrun and keep the newer byte; a frame at 372 clocks per bit, which catches a counter that is too narrow; and a reset mid-frame. The time of each `frame_end` is checked to the exact clock, which exposes an off-by-one in the bit counter.

// File: rtl/sc_rx_pkg.sv
package sc_rx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PARITY,
      ST_STOP1,
      ST_STOP2
   } rx_state_t;

   localparam int MIN_PERIOD_W = 13;
endpackage

// File: rtl/sc_rx_bitclk.sv
// Bit timer: counts clocks within one bit and flags the centre and last clock.
module sc_rx_bitclk #(
   parameter int PERIOD_W = 13
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run,
   input  logic [PERIOD_W-1:0] period,
   output logic                mid_tick,
   output logic                end_tick
);
   logic [PERIOD_W-1:0] cnt;
   logic [PERIOD_W-1:0] half;
   logic [PERIOD_W-1:0] last;

   assign half     = period >> 1;
   assign last     = period - PERIOD_W'(1);
   assign mid_tick = run && (cnt == half);
   assign end_tick = run && (cnt == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run || end_tick) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + PERIOD_W'(1);
      end
   end
endmodule

// File: rtl/sc_rx_shift.sv
// Data shifter: assembles the byte in either bit order.
module sc_rx_shift #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              bit_in,
   input  logic              msb_first,
   output logic [DATA_W-1:0] data
);
   logic [DATA_W-1:0] nxt_lsb;
   logic [DATA_W-1:0] nxt_msb;

   generate
      if (DATA_W == 1) begin : g_single
         assign nxt_lsb = bit_in;
         assign nxt_msb = bit_in;
      end else begin : g_multi
         assign nxt_lsb = {bit_in, data[DATA_W-1:1]};
         assign nxt_msb = {data[DATA_W-2:0], bit_in};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data <= '0;
      end else if (shift_en) begin
         data <= msb_first ? nxt_msb : nxt_lsb;
      end
   end
endmodule

// File: rtl/sc_rx_flags.sv
// Result flags and holding register for the received byte.
module sc_rx_flags #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done,
   input  logic              good,
   input  logic [DATA_W-1:0] data,
   input  logic              ack,
   output logic [DATA_W-1:0] rx_byte,
   output logic              byte_ready,
   output logic              overrun_err,
   output logic              frame_err
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_byte     <= '0;
         byte_ready  <= 1'b0;
         overrun_err <= 1'b0;
         frame_err   <= 1'b0;
      end else begin
         if (ack) begin
            byte_ready  <= 1'b0;
            overrun_err <= 1'b0;
            frame_err   <= 1'b0;
         end
         if (done) begin
            if (good) begin
               rx_byte    <= data;
               byte_ready <= 1'b1;
               if (byte_ready && !ack) begin
                  overrun_err <= 1'b1;
               end
            end else begin
               frame_err <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/sc_serial_rx.sv
module sc_serial_rx
   import sc_rx_pkg::*;
#(
   parameter int PERIOD_W    = 13,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                line_in,
   input  logic [PERIOD_W-1:0] bit_period,
   input  logic                msb_first,
   input  logic                odd_parity,
   input  logic                two_stop,
   input  logic                ack,
   output logic [DATA_W-1:0]   rx_byte,
   output logic                byte_ready,
   output logic                overrun_err,
   output logic                frame_err,
   output logic                start_seen,
   output logic                rx_active,
   output logic                frame_end
);
   localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

   generate
      if (PERIOD_W < MIN_PERIOD_W) begin : g_bad_period_w
         $error("sc_serial_rx: PERIOD_W must be at least 13");
      end
      if (DATA_W < 1) begin : g_bad_data_w
         $error("sc_serial_rx: DATA_W must be positive");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("sc_serial_rx: SYNC_STAGES must not be negative");
      end
   endgenerate

   // Line synchroniser, depth chosen by parameter
   logic line_s;
   logic line_q;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign line_s = line_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sync_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sync_r <= '1;
            end else begin
               sync_r[0] <= line_in;
               for (int i = 1; i < SYNC_STAGES; i++) begin
                  sync_r[i] <= sync_r[i-1];
               end
            end
         end
         assign line_s = sync_r[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_q <= 1'b1;
      else        line_q <= line_s;
   end

   rx_state_t state;

   // Configuration held for the whole frame
   logic [PERIOD_W-1:0] cfg_period;
   logic                cfg_msb;
   logic                cfg_odd;
   logic                cfg_two;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_period <= '0;
         cfg_msb    <= 1'b0;
         cfg_odd    <= 1'b0;
         cfg_two    <= 1'b0;
      end else if (state == ST_IDLE) begin
         cfg_period <= bit_period;
         cfg_msb    <= msb_first;
         cfg_odd    <= odd_parity;
         cfg_two    <= two_stop;
      end
   end

   logic mid_tick;
   logic end_tick;

   sc_rx_bitclk #(.PERIOD_W(PERIOD_W)) u_bitclk (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (state != ST_IDLE),
      .period   (cfg_period),
      .mid_tick (mid_tick),
      .end_tick (end_tick)
   );

   logic [DATA_W-1:0] shift_data;

   sc_rx_shift #(.DATA_W(DATA_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .shift_en  (mid_tick && (state == ST_DATA)),
      .bit_in    (line_s),
      .msb_first (cfg_msb),
      .data      (shift_data)
   );

   logic [IDX_W-1:0] bit_idx;
   logic             par_bit;
   logic             stop_bad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         bit_idx   <= '0;
         par_bit   <= 1'b0;
         stop_bad  <= 1'b0;
         rx_active <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (line_q && !line_s) begin
                  state    <= ST_START;
                  stop_bad <= 1'b0;
               end
            end
            ST_START: begin
               if (mid_tick) begin
                  if (line_s) state     <= ST_IDLE;
                  else        rx_active <= 1'b1;
               end else if (end_tick) begin
                  state   <= ST_DATA;
                  bit_idx <= '0;
               end
            end
            ST_DATA: begin
               if (end_tick) begin
                  if (bit_idx == IDX_W'(DATA_W - 1)) state <= ST_PARITY;
                  else bit_idx <= bit_idx + IDX_W'(1);
               end
            end
            ST_PARITY: begin
               if (mid_tick) par_bit <= line_s;
               if (end_tick) state   <= ST_STOP1;
            end
            ST_STOP1: begin
               if (mid_tick && !line_s) stop_bad <= 1'b1;
               if (end_tick) begin
                  if (cfg_two) begin
                     state <= ST_STOP2;
                  end else begin
                     state     <= ST_IDLE;
                     rx_active <= 1'b0;
                  end
               end
            end
            ST_STOP2: begin
               if (mid_tick && !line_s) stop_bad <= 1'b1;
               if (end_tick) begin
                  state     <= ST_IDLE;
                  rx_active <= 1'b0;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   logic parity_bad;
   assign parity_bad = ((^shift_data) ^ par_bit) != cfg_odd;
   assign start_seen = (state == ST_START);
   assign frame_end  = end_tick &&
                       (((state == ST_STOP1) && !cfg_two) || (state == ST_STOP2));

   sc_rx_flags #(.DATA_W(DATA_W)) u_flags (
      .clk         (clk),
      .rst_n       (rst_n),
      .done        (frame_end),
      .good        (!parity_bad && !stop_bad),
      .data        (shift_data),
      .ack         (ack),
      .rx_byte     (rx_byte),
      .byte_ready  (byte_ready),
      .overrun_err (overrun_err),
      .frame_err   (frame_err)
   );
endmodule

// File: rtl/sc_serial_rx_chk.sv
module sc_serial_rx_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ack,
   input logic [DATA_W-1:0] rx_byte,
   input logic              byte_ready,
   input logic              overrun_err,
   input logic              frame_err,
   input logic              start_seen,
   input logic              rx_active,
   input logic              frame_end
);
   AST_FE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |=> !frame_end); // R7

   AST_ACTIVE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_active) |-> $past(start_seen)); // R8

   AST_END_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |-> rx_active); // R9

   AST_END_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |=> (byte_ready || frame_err)); // R9

   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !frame_end) |=> (!byte_ready && !overrun_err && !frame_err)); // R10

   AST_OVR_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun_err) |-> $past(byte_ready)); // R6

   AST_BYTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_end |=> $stable(rx_byte)); // R5
endmodule

bind sc_serial_rx sc_serial_rx_chk #(.DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ack         (ack),
   .rx_byte     (rx_byte),
   .byte_ready  (byte_ready),
   .overrun_err (overrun_err),
   .frame_err   (frame_err),
   .start_seen  (start_seen),
   .rx_active   (rx_active),
   .frame_end   (frame_end)
);

// File: tb/sc_serial_rx_tb.sv
module sc_serial_rx_tb;
   localparam int CLK_PERIOD = 10;
   localparam int PW   = 13;
   localparam int SYNC = 2;
   localparam int WD_LIMIT = 150000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          line_in = 1'b1;
   logic [PW-1:0] bit_period = PW'(16);
   logic          msb_first = 1'b0;
   logic          odd_parity = 1'b0;
   logic          two_stop = 1'b0;
   logic          ack = 1'b0;
   logic [7:0]    rx_byte;
   logic          byte_ready, overrun_err, frame_err;
   logic          start_seen, rx_active, frame_end;

   sc_serial_rx #(.PERIOD_W(PW), .DATA_W(8), .SYNC_STAGES(SYNC)) u_dut (
      .clk(clk), .rst_n(rst_n), .line_in(line_in), .bit_period(bit_period),
      .msb_first(msb_first), .odd_parity(odd_parity), .two_stop(two_stop),
      .ack(ack), .rx_byte(rx_byte), .byte_ready(byte_ready),
      .overrun_err(overrun_err), .frame_err(frame_err),
      .start_seen(start_seen), .rx_active(rx_active), .frame_end(frame_end)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   int fe_cnt = 0;
   int fe_cyc = -1;
   int ss_cnt = 0;
   int act_cnt = 0;
   bit fe_prev = 1'b0;
   bit ss_prev = 1'b0;
   bit done = 1'b0;
   int t0 = 0;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (frame_end) begin
         fe_cnt = fe_cnt + 1;
         fe_cyc = cyc;
         if (fe_prev) begin
            n_chk++; n_fail++;
            $display("FAIL R7: frame_end width act=2+ exp=1");
         end
      end
      if (start_seen && !ss_prev) ss_cnt = ss_cnt + 1;
      if (rx_active) act_cnt = act_cnt + 1;
      fe_prev = frame_end;
      ss_prev = start_seen;
   end

   always @(posedge clk) begin
      if (cyc > WD_LIMIT && !done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: act=%0d exp<=%0d cycles", cyc, WD_LIMIT);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
      end
   endtask

   function automatic logic par_of(input logic [7:0] d, input logic odd);
      return (^d) ^ odd;
   endfunction

   function automatic logic bit_at(input logic [7:0] d, input int i, input logic msb);
      return msb ? d[7-i] : d[i];
   endfunction

   function automatic int frame_bits(input logic two);
      return two ? 12 : 11;
   endfunction

   task automatic hold_line(input logic v, input int n);
      line_in = v;
      repeat (n) @(negedge clk);
   endtask

   // stop_bad: 0 none, 1 first stop low, 2 second stop low; flip: change config mid-frame
   task automatic send(input logic [7:0] d, input int p, input logic msb, input logic odd,
                       input logic two, input bit bad_par, input int stop_bad, input bit flip);
      bit_period = PW'(p);
      msb_first  = msb;
      odd_parity = odd;
      two_stop   = two;
      @(negedge clk);
      t0 = cyc;
      hold_line(1'b0, p);
      for (int i = 0; i < 8; i++) begin
         if (flip && i == 4) begin
            msb_first  = ~msb;
            odd_parity = ~odd;
            two_stop   = ~two;
            bit_period = PW'(p + 3);
         end
         hold_line(bit_at(d, i, msb), p);
      end
      hold_line(par_of(d, odd) ^ bad_par, p);
      hold_line(stop_bad != 1, p);
      if (two) hold_line(stop_bad != 2, p);
      line_in = 1'b1;
      repeat (SYNC + 4) @(negedge clk);
      msb_first  = msb;
      odd_parity = odd;
      two_stop   = two;
      bit_period = PW'(p);
   endtask

   task automatic pulse_ack();
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
      @(negedge clk);
   endtask

   task automatic good_frame(input string req, input logic [7:0] d, input int p,
                             input logic msb, input logic odd, input logic two, input bit flip);
      int fe0;
      fe0 = fe_cnt;
      send(d, p, msb, odd, two, 1'b0, 0, flip);
      check({req, " byte"}, rx_byte, d);
      check({req, " ready"}, byte_ready, 1);
      check({req, " frame_err"}, frame_err, 0);
      check({req, " R7 end count"}, fe_cnt - fe0, 1);
      check({req, " R7 end time"}, fe_cyc, t0 + SYNC + frame_bits(two) * p);
      pulse_ack();
   endtask

   initial begin
      int fe0;
      logic [7:0] d;
      void'($urandom(32'd5150));
      repeat (3) @(negedge clk);
      // R12 reset state
      check("R12 reset ready", byte_ready, 0);
      check("R12 reset frame_err", frame_err, 0);
      check("R12 reset active", {start_seen, rx_active, frame_end}, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R1 long smart-card period
      good_frame("R1 372", 8'hA5, 372, 1'b0, 1'b0, 1'b0, 1'b0);

      // R2 R3 R4 directed orderings
      good_frame("R2 lsb", 8'h01, 16, 1'b0, 1'b1, 1'b0, 1'b0);
      good_frame("R2 msb", 8'h01, 16, 1'b1, 1'b1, 1'b0, 1'b0);
      good_frame("R3 even zeros", 8'h00, 12, 1'b0, 1'b0, 1'b1, 1'b0);
      good_frame("R3 odd ones", 8'hFF, 12, 1'b1, 1'b1, 1'b1, 1'b0);

      // R9 random good frames
      for (int k = 0; k < 20; k++) begin
         good_frame("R9 rand", 8'($urandom), 8 + int'($urandom % 33),
                    1'($urandom), 1'($urandom), 1'($urandom), 1'b0);
      end

      // R11 config flipped mid-frame
      good_frame("R11 flip", 8'h3C ^ 8'($urandom), 20, 1'b0, 1'b1, 1'b1, 1'b1);
      good_frame("R11 flip2", 8'hC1, 14, 1'b1, 1'b0, 1'b0, 1'b1);

      // R5 parity fault
      for (int k = 0; k < 3; k++) begin
         d = 8'($urandom);
         send(d, 10 + k * 5, 1'($urandom), 1'($urandom), 1'($urandom), 1'b1, 0, 1'b0);
         check("R5 parity frame_err", frame_err, 1);
         check("R5 parity ready", byte_ready, 0);
         check("R5 parity byte held", rx_byte, 8'hC1);
         pulse_ack();
         check("R10 ack clears", {byte_ready, overrun_err, frame_err}, 0);
      end

      // R4 stop-bit faults
      send(8'h5A, 16, 1'b0, 1'b0, 1'b0, 1'b0, 1, 1'b0);
      check("R4 one stop low", frame_err, 1);
      hold_line(1'b1, 40);
      pulse_ack();
      send(8'h5A, 16, 1'b0, 1'b0, 1'b1, 1'b0, 2, 1'b0);
      check("R4 second stop low", frame_err, 1);
      check("R4 second stop ready", byte_ready, 0);
      hold_line(1'b1, 40);
      pulse_ack();

      // R6 overrun
      send(8'h11, 16, 1'b0, 1'b1, 1'b0, 1'b0, 0, 1'b0);
      check("R6 first ready", {byte_ready, overrun_err}, 2'b10);
      send(8'h22, 16, 1'b0, 1'b1, 1'b0, 1'b0, 0, 1'b0);
      check("R6 overrun", {byte_ready, overrun_err}, 2'b11);
      check("R6 newest byte", rx_byte, 8'h22);

      // R8 glitch rejection
      fe0 = fe_cnt;
      ss_cnt = 0;
      act_cnt = 0;
      bit_period = PW'(24);
      @(negedge clk);
      hold_line(1'b0, 5);
      hold_line(1'b1, 60);
      check("R8 start_seen rose", ss_cnt, 1);
      check("R8 no rx_active", act_cnt, 0);
      check("R8 no frame_end", fe_cnt - fe0, 0);
      check("R8 flags kept", {byte_ready, overrun_err, frame_err}, 3'b110);

      // R12 reset mid-frame
      bit_period = PW'(20);
      @(negedge clk);
      hold_line(1'b0, 50);
      check("R8 active after confirm", rx_active, 1);
      rst_n = 1'b0;
      @(negedge clk);
      check("R12 mid reset flags", {byte_ready, overrun_err, frame_err}, 0);
      check("R12 mid reset progress", {start_seen, rx_active, frame_end}, 0);
      line_in = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      good_frame("R12 after reset", 8'h96, 18, 1'b1, 1'b0, 1'b1, 1'b0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule